// File: doc/BRIEF.md
# Port-Budgeted Issue Selector

This block is the select stage of a wide out-of-order core. Every cycle it looks at the ready entries of an issue window and grants up to `W` of them. It also makes sure that the register-file read ports those grants consume never exceed a fixed budget `P`. That budget is normally well below two ports per issue slot. For example, an 8-wide core can be served by a 10-, 11- or 12-port register file instead of 16, and a 4-wide core by a correspondingly smaller one.

Each window entry presents four things:
- a ready bit;
- an age rank, where a lower value is older;
- a source count, where a two-source instruction consumes two read ports;
- up to two 7-bit register indices, for a 128-entry register file.

Entries are considered strictly oldest first. An entry that does not fit the ports that are left is passed over, and younger entries with a smaller demand may still take the ports that remain. The outputs are registered on the rising clock edge:
- a grant vector over the window;
- for each read port, a valid bit, the register index it reads and the window entry that owns it.

The block keeps no memory between cycles. A request that is not granted and is presented again is simply considered again. Wakeup, the register file, bypass and functional units sit outside the block.

Top module: `port_budget_select`

## Requirements
- R1: At most `W` entries are granted in one cycle.
- R2: The source code is decoded as follows: 0 needs no port, 1 needs one, and 2 or 3 need two. The number of valid ports equals the summed demand of the granted entries and never exceeds `P`.
- R3: Entries are visited in age order. A lower rank is older, and on equal ranks the lower window index is older. A visited ready entry is granted exactly when an issue slot remains and its demand fits in the ports still free after all older entries were decided.
- R4: When an older two-source entry does not fit, a younger entry with a demand of one or zero that does fit is still granted in the same cycle.
- R5: Ports are filled from index 0 upward without gaps, in grant order (oldest grant first). A two-source grant takes two consecutive ports: the first reads `src0` and the second reads `src1`. A one-source grant reads `src0`. Every valid port names its owning entry, and that entry is granted.
- R6: The outputs reflect the inputs sampled at the previous rising edge, and nothing carries over between cycles. An ungranted request that is presented again is evaluated afresh.
- R7: A synchronous active-high reset clears the grants, the port valid bits, the register indices and the owner fields.
- R8: An entry whose ready bit is low is never granted and receives no port.
- R9: A ready zero-source entry uses an issue slot but no port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_rdy | input | N | Ready bit per window entry |
| req_rank | input | N*RW | Age rank per entry, lower is older |
| req_nsrc | input | 2*N | Source-register count per entry |
| req_src0 | input | N*AW | First source register index per entry |
| req_src1 | input | N*AW | Second source register index per entry |
| gnt | output | N | Registered grant per entry |
| port_vld | output | P | Registered valid bit per read port |
| port_reg | output | P*AW | Register index driven onto each read port |
| port_ent | output | P*EW | Window entry owning each read port |

## Verification
The issue-width limit and the port budget can bind in the same cycle. Whichever one runs out first decides whether a younger small request is still admitted after an older two-source request has been refused. Random vectors mix ready densities, tied ranks and skewed source counts so that both limits are hit together, and directed vectors force the window-full and port-full cases separately. Every registered output is compared with a bench model that sorts the window by age and allocates ports greedily. The model also checks that the slot limit and the port budget are never exceeded.

// File: rtl/port_budget_select.sv
module port_budget_select #(
  parameter int N  = 16,
  parameter int W  = 8,
  parameter int P  = 11,
  parameter int RW = 4,
  parameter int AW = 7,
  localparam int EW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N-1:0]    req_rdy,
  input  logic [N*RW-1:0] req_rank,
  input  logic [2*N-1:0]  req_nsrc,
  input  logic [N*AW-1:0] req_src0,
  input  logic [N*AW-1:0] req_src1,
  output logic [N-1:0]    gnt,
  output logic [P-1:0]    port_vld,
  output logic [P*AW-1:0] port_reg,
  output logic [P*EW-1:0] port_ent
);

  function automatic int demand(input logic [1:0] c);
    return (c == 2'd0) ? 0 : (c == 2'd1) ? 1 : 2;
  endfunction

  int pos [N];

  always_comb begin
    for (int i = 0; i < N; i++) begin
      pos[i] = 0;
      for (int j = 0; j < N; j++) begin
        if (j != i) begin
          if ((req_rank[j*RW +: RW] < req_rank[i*RW +: RW]) ||
              ((req_rank[j*RW +: RW] == req_rank[i*RW +: RW]) && (j < i)))
            pos[i] = pos[i] + 1;
        end
      end
    end
  end

  logic [N-1:0]    g_n;
  logic [P-1:0]    v_n;
  logic [P*AW-1:0] r_n;
  logic [P*EW-1:0] e_n;

  always_comb begin
    int used;
    int slots;
    int d;
    g_n   = '0;
    v_n   = '0;
    r_n   = '0;
    e_n   = '0;
    used  = 0;
    slots = 0;
    d     = 0;
    for (int p = 0; p < N; p++) begin
      for (int i = 0; i < N; i++) begin
        if (pos[i] == p && req_rdy[i]) begin
          d = demand(req_nsrc[2*i +: 2]);
          if (slots < W && used + d <= P) begin
            g_n[i] = 1'b1;
            slots  = slots + 1;
            if (d > 0) begin
              v_n[used]             = 1'b1;
              r_n[used*AW +: AW]    = req_src0[i*AW +: AW];
              e_n[used*EW +: EW]    = EW'(i);
            end
            if (d > 1) begin
              v_n[used+1]           = 1'b1;
              r_n[(used+1)*AW +: AW] = req_src1[i*AW +: AW];
              e_n[(used+1)*EW +: EW] = EW'(i);
            end
            used = used + d;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt      <= '0;
      port_vld <= '0;
      port_reg <= '0;
      port_ent <= '0;
    end else begin
      gnt      <= g_n;
      port_vld <= v_n;
      port_reg <= r_n;
      port_ent <= e_n;
    end
  end

endmodule

// File: rtl/port_budget_select_chk.sv
module port_budget_select_chk #(
  parameter int N  = 16,
  parameter int W  = 8,
  parameter int P  = 11,
  parameter int RW = 4,
  parameter int AW = 7,
  localparam int EW = (N > 1) ? $clog2(N) : 1
) (
  input logic            clk,
  input logic            rst,
  input logic [N-1:0]    req_rdy,
  input logic [2*N-1:0]  req_nsrc,
  input logic [N-1:0]    gnt,
  input logic [P-1:0]    port_vld,
  input logic [P*EW-1:0] port_ent
);

  logic [N-1:0]   rdy_q;
  logic [2*N-1:0] nsrc_q;

  always_ff @(posedge clk) begin
    rdy_q  <= req_rdy;
    nsrc_q <= req_nsrc;
  end

  function automatic int dsum(input logic [N-1:0] g, input logic [2*N-1:0] c);
    int s;
    s = 0;
    for (int i = 0; i < N; i++)
      if (g[i]) s = s + ((c[2*i +: 2] == 2'd0) ? 0 : (c[2*i +: 2] == 2'd1) ? 1 : 2);
    return s;
  endfunction

  AST_SLOT_CAP: assert property (@(posedge clk) disable iff (rst)
    $countones(gnt) <= W); // R1

  AST_PORT_SUM: assert property (@(posedge clk) disable iff (rst)
    $countones(port_vld) == dsum(gnt, nsrc_q)); // R2

  AST_PORT_PACKED: assert property (@(posedge clk) disable iff (rst)
    (port_vld & (port_vld + P'(1))) == '0); // R5

  AST_READY_ONLY: assert property (@(posedge clk) disable iff (rst)
    (gnt & ~rdy_q) == '0); // R8

  AST_RESET_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> (gnt == '0 && port_vld == '0)); // R7

  for (genvar k = 0; k < P; k++) begin : g_own
    AST_PORT_OWNER: assert property (@(posedge clk) disable iff (rst)
      port_vld[k] |-> gnt[port_ent[k*EW +: EW]]); // R5
  end

endmodule

bind port_budget_select port_budget_select_chk #(
  .N(N), .W(W), .P(P), .RW(RW), .AW(AW)
) chk_i (
  .clk(clk), .rst(rst), .req_rdy(req_rdy), .req_nsrc(req_nsrc),
  .gnt(gnt), .port_vld(port_vld), .port_ent(port_ent)
);

// File: tb/port_budget_select_tb_top.sv
module port_budget_select_tb_top;
  localparam int N = 16, W = 8, P = 11, RW = 4, AW = 7, EW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0]    rdy;
  logic [N*RW-1:0] rank;
  logic [2*N-1:0]  nsrc;
  logic [N*AW-1:0] s0, s1;
  logic [N-1:0]    gnt;
  logic [P-1:0]    pv;
  logic [P*AW-1:0] pr;
  logic [P*EW-1:0] pe;

  logic [N-1:0]    eg;
  logic [P-1:0]    ev;
  logic [P*AW-1:0] er;
  logic [P*EW-1:0] ee;
  logic [N-1:0]    prev_g;

  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  port_budget_select #(.N(N), .W(W), .P(P), .RW(RW), .AW(AW)) dut_i (
    .clk(clk), .rst(rst), .req_rdy(rdy), .req_rank(rank), .req_nsrc(nsrc),
    .req_src0(s0), .req_src1(s1), .gnt(gnt), .port_vld(pv),
    .port_reg(pr), .port_ent(pe));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model();
    bit done [N];
    int used, slots, d, best;
    eg = '0; ev = '0; er = '0; ee = '0;
    used = 0; slots = 0;
    for (int i = 0; i < N; i++) done[i] = 0;
    for (int k = 0; k < N; k++) begin
      best = -1;
      for (int i = 0; i < N; i++)
        if (!done[i] && (best < 0 || rank[i*RW +: RW] < rank[best*RW +: RW])) best = i;
      done[best] = 1;
      d = (nsrc[2*best +: 2] == 0) ? 0 : (nsrc[2*best +: 2] == 1) ? 1 : 2;
      if (rdy[best] && slots < W && used + d <= P) begin
        eg[best] = 1'b1; slots++;
        for (int q = 0; q < d; q++) begin
          ev[used+q] = 1'b1;
          er[(used+q)*AW +: AW] = (q == 0) ? s0[best*AW +: AW] : s1[best*AW +: AW];
          ee[(used+q)*EW +: EW] = EW'(best);
        end
        used += d;
      end
    end
  endtask

  task automatic apply_and_check();
    model();
    @(posedge clk);
    @(negedge clk);
    chk(gnt == eg, "R3 grant", 64'(gnt), 64'(eg));
    chk(pv == ev, "R2 port valid", 64'(pv), 64'(ev));
    chk(pr == er, "R5 port register", 64'(pr), 64'(er));
    chk(pe == ee, "R5 port owner", 64'(pe), 64'(ee));
    chk($countones(gnt) <= W, "R1 slot cap", 64'($countones(gnt)), 64'(W));
    chk((gnt & ~rdy) == '0, "R8 not ready", 64'(gnt), 64'(rdy));
  endtask

  task automatic fill_rand();
    int dens;
    dens = $urandom_range(0, 3);
    for (int i = 0; i < N; i++) begin
      rdy[i] = ($urandom_range(0, 3) >= dens);
      rank[i*RW +: RW] = RW'($urandom_range(0, 15));
      nsrc[2*i +: 2] = ($urandom_range(0, 9) < 6) ? 2'd2 : 2'($urandom_range(0, 3));
      s0[i*AW +: AW] = AW'($urandom);
      s1[i*AW +: AW] = AW'($urandom);
    end
  endtask

  initial begin
    #(8 * 200000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2025));
    rdy = '1; rank = '0; nsrc = '1; s0 = '1; s1 = '1;
    repeat (3) @(negedge clk);
    chk(gnt == '0 && pv == '0 && pr == '0 && pe == '0, "R7 reset state", 64'(gnt), 64'h0);
    rst = 1'b0;

    // R4: six older two-source, then one-source entries
    rdy = '0; nsrc = '0;
    for (int i = 0; i < N; i++) begin
      rank[i*RW +: RW] = RW'(i);
      s0[i*AW +: AW] = AW'(i + 1);
      s1[i*AW +: AW] = AW'(i + 64);
    end
    for (int i = 0; i < 6; i++) begin rdy[i] = 1'b1; nsrc[2*i +: 2] = 2'd2; end
    rdy[6] = 1'b1; nsrc[12 +: 2] = 2'd1;
    rdy[7] = 1'b1; nsrc[14 +: 2] = 2'd1;
    apply_and_check();
    chk(gnt == 16'h005F, "R4 younger bypass", 64'(gnt), 64'h005F);
    chk(pv == '1, "R2 budget full", 64'(pv), 64'h7FF);

    // R6: same vector again yields the same result
    prev_g = gnt;
    apply_and_check();
    chk(gnt == prev_g, "R6 repeat stateless", 64'(gnt), 64'(prev_g));

    // R9 / R1: sixteen zero-source entries, reversed ages
    rdy = '1; nsrc = '0;
    for (int i = 0; i < N; i++) rank[i*RW +: RW] = RW'(15 - i);
    apply_and_check();
    chk(gnt == 16'hFF00 && pv == '0, "R9 zero source", 64'(gnt), 64'hFF00);

    // R8: nothing ready
    rdy = '0; nsrc = '1;
    apply_and_check();
    chk(gnt == '0, "R8 idle", 64'(gnt), 64'h0);

    // R3: all ranks tied, code 3 counts as two ports
    rdy = '1; rank = '0; nsrc = '1;
    apply_and_check();
    chk(gnt == 16'h001F, "R3 tie by index", 64'(gnt), 64'h001F);

    // R7: reset in mid stream
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(gnt == '0 && pv == '0, "R7 mid reset", 64'(gnt), 64'h0);
    rst = 1'b0;

    for (int v = 0; v < 400; v++) begin
      fill_rand();
      apply_and_check();
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule